// File: doc/BRIEF.md
# Three-Wire Converter Device Emulator

This block stands in for a serial 12-bit converter on a three-wire bus. A host drives a conversion-start line and a serial clock. The block answers on a serial data line and drives a separate output-enable for that line. A rising edge on the conversion-start line captures a parallel sample word. The block then counts out a conversion time. When that time ends and the start line is still high, the block sleeps and keeps the word. When the start line falls, the block presents the most significant bit of the word at once. Each falling serial clock edge then moves to the next lower bit, and once the word is used up the line carries zeros for as long as the host keeps clocking.

Both host lines are asynchronous to the system clock. Each passes through a flip-flop synchronizer, and edges are found on the synchronized copies. The block reports its current phase on a status output. It also raises a one-cycle flag when the host starts a new conversion before the acquisition time has run out. The block can serve as a loopback target in a bench or as a bus emulator on a board.

Top module: `adc_emu_top`

## Requirements
- R1: A rising edge on `convIn` changes the phase three system clocks after the edge is first sampled, moving it to converting (code 1). At that same clock `sampleIn` is captured as the word to send, and `sdoEn` goes low.
- R2: If `convIn` stays high, the converting phase lasts exactly CONV_CYCLES clocks and then becomes sleep (code 2). Sleep holds until `convIn` falls.
- R3: A falling edge on `convIn` during converting or sleep moves the phase to acquiring (code 3) and raises `sdoEn`. From that clock `sdoOut` equals bit 11 of the captured word.
- R4: Each falling edge on `sckIn` while `convIn` is low and `sdoEn` is high moves `sdoOut` to the next lower bit of the word.
- R5: Once bit 0 has been shifted out, every further falling `sckIn` edge keeps `sdoOut` at zero, with no limit.
- R6: The acquiring phase lasts exactly ACQ_CYCLES clocks and then becomes shifting (code 4). The data line stays enabled in the shifting phase.
- R7: A rising `convIn` edge detected in the acquiring phase pulses `acqViolation` high for one clock, and the new conversion still starts. A rising edge detected in the shifting phase does not pulse the flag.
- R8: During and right after reset the phase is idle (code 0), and `sdoEn`, `sdoOut` and `acqViolation` are all low.
- R9: `sdoOut` is low in every cycle where `sdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convIn | input | 1 | Conversion-start line from the host, asynchronous |
| sckIn | input | 1 | Serial clock from the host, asynchronous |
| sampleIn | input | DATA_W | Parallel sample word, captured at conversion start |
| sdoOut | output | 1 | Serial data toward the host |
| sdoEn | output | 1 | Output enable for the serial data line |
| phase | output | 3 | Phase code: 0 idle, 1 converting, 2 sleep, 3 acquiring, 4 shifting |
| acqViolation | output | 1 | One-clock pulse when a conversion starts during acquisition |

## Verification
The bench runs several stimulus patterns:
- A long high pulse on the start line, which separates reaching sleep from going straight to acquisition.
- A short pulse that falls while the block is still converting.
- A start that comes back early, inside the acquisition window, to trigger the violation flag.
- A start that comes back after acquisition has finished, which must not raise the flag.

The sample words include alternating bits, a single low one, a single high one and all ones, so that bit order and the zero fill after the last bit can be told apart. The clock-by-clock model tracks a bit index and not a shift register. It therefore catches off-by-one errors in how many bits are sent and in how long each phase lasts.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CONVERT = 3'd1,
    PH_SLEEP   = 3'd2,
    PH_ACQUIRE = 3'd3,
    PH_SHIFT   = 3'd4
  } phase_e;

  typedef struct packed {
    logic loadSample;
    logic presentWord;
    logic shiftBit;
  } dpStrobe_t;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
  import adc_emu_pkg::*;
#(
  parameter int CONV_CYCLES = 8,
  parameter int ACQ_CYCLES  = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      convSync,
  input  logic      sckSync,
  output phase_e    phase,
  output dpStrobe_t strobe,
  output logic      acqViolation
);
  localparam int TMR_MAX = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] CONV_LOAD = TMR_W'(CONV_CYCLES - 1);
  localparam logic [TMR_W-1:0] ACQ_LOAD  = TMR_W'(ACQ_CYCLES - 1);

  phase_e           state, stateNext;
  logic [TMR_W-1:0] tmr, tmrNext;
  logic             convPrev, sckPrev;
  logic             convRise, convFall, sckFall;
  logic             lineActive;

  assign convRise   = convSync & ~convPrev;
  assign convFall   = ~convSync & convPrev;
  assign sckFall    = ~sckSync & sckPrev;
  assign lineActive = (state == PH_ACQUIRE) || (state == PH_SHIFT);

  always_comb begin
    stateNext = state;
    tmrNext   = tmr;
    unique case (state)
      PH_IDLE: if (convRise) begin
        stateNext = PH_CONVERT;
        tmrNext   = CONV_LOAD;
      end
      PH_CONVERT, PH_SLEEP: begin
        if (convFall) begin
          stateNext = PH_ACQUIRE;
          tmrNext   = ACQ_LOAD;
        end else if (state == PH_CONVERT) begin
          if (tmr == '0) stateNext = PH_SLEEP;
          else           tmrNext   = tmr - 1'b1;
        end
      end
      PH_ACQUIRE, PH_SHIFT: begin
        if (convRise) begin
          stateNext = PH_CONVERT;
          tmrNext   = CONV_LOAD;
        end else if (state == PH_ACQUIRE) begin
          if (tmr == '0) stateNext = PH_SHIFT;
          else           tmrNext   = tmr - 1'b1;
        end
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadSample  = convRise;
    strobe.presentWord = convFall && ((state == PH_CONVERT) || (state == PH_SLEEP));
    strobe.shiftBit    = sckFall && !convSync && lineActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= PH_IDLE;
      tmr          <= '0;
      convPrev     <= 1'b0;
      sckPrev      <= 1'b0;
      acqViolation <= 1'b0;
    end else begin
      state        <= stateNext;
      tmr          <= tmrNext;
      convPrev     <= convSync;
      sckPrev      <= sckSync;
      acqViolation <= convRise && (state == PH_ACQUIRE);
    end
  end

  assign phase = state;

  AST_RISE_CONVERTS: assert property (@(posedge clk) disable iff (!rstN)
    convRise |=> state == PH_CONVERT); // R1
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SLEEP) && !convFall |=> state == PH_SLEEP); // R2
  AST_FALL_ACQUIRES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.presentWord |=> state == PH_ACQUIRE); // R3
  AST_VIOLATION_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    acqViolation |-> $past(state) == PH_ACQUIRE); // R7
  AST_VIOLATION_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    acqViolation |=> !acqViolation); // R7
endmodule

// File: rtl/adc_emu_dp.sv
module adc_emu_dp
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              shiftMsb
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.loadSample) holdReg <= sampleIn;
      if (strobe.presentWord)   shiftReg <= holdReg;
      else if (strobe.shiftBit) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign shiftMsb = shiftReg[DATA_W-1];

  AST_SAMPLE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSample |=> holdReg == $past(sampleIn)); // R1
  AST_WORD_PRESENTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.presentWord |=> shiftReg == $past(holdReg)); // R3
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftBit && !strobe.presentWord && (shiftReg[DATA_W-2:0] == '0) |=> shiftReg == '0); // R5
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftBit && !strobe.presentWord |=> $stable(shiftReg)); // R4
endmodule

// File: rtl/adc_emu_top.sv
module adc_emu_top
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 8,
  parameter int ACQ_CYCLES  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convIn,
  input  logic              sckIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic [2:0]        phase,
  output logic              acqViolation
);
  logic      convSync, sckSync, shiftMsb;
  phase_e    phaseInt;
  dpStrobe_t strobe;

  adc_emu_sync #(.STAGES(SYNC_STAGES)) i_convSync (
    .clk(clk), .rstN(rstN), .asyncIn(convIn), .syncOut(convSync));
  adc_emu_sync #(.STAGES(SYNC_STAGES)) i_sckSync (
    .clk(clk), .rstN(rstN), .asyncIn(sckIn), .syncOut(sckSync));

  adc_emu_ctrl #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .convSync(convSync), .sckSync(sckSync),
    .phase(phaseInt), .strobe(strobe), .acqViolation(acqViolation));

  adc_emu_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn), .shiftMsb(shiftMsb));

  assign sdoEn  = (phaseInt == PH_ACQUIRE) || (phaseInt == PH_SHIFT);
  assign sdoOut = sdoEn & shiftMsb;
  assign phase  = phaseInt;

  AST_EN_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.presentWord |=> sdoEn); // R3
  AST_EN_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSample |=> !sdoEn); // R1
endmodule

// File: tb/test_adc_emu_top.sv
module test_adc_emu_top;
  localparam int DATA_W = 12;
  localparam int CONV_CYCLES = 8;
  localparam int ACQ_CYCLES = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convIn = 1'b0;
  logic sckIn = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic sdoOut, sdoEn, acqViolation;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  int violSeen = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_emu_top #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES))
    i_adc_emu_top (.clk(clk), .rstN(rstN), .convIn(convIn), .sckIn(sckIn),
      .sampleIn(sampleIn), .sdoOut(sdoOut), .sdoEn(sdoEn), .phase(phase),
      .acqViolation(acqViolation));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: synchronizer delay line, phase number, bit index
  int mPhase, mCnt, mIdx;
  logic [DATA_W-1:0] mWord;
  logic mViol, c0, c1, cp, s0, s1, sp;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mIdx = -1; mWord = '0; mViol = 0;
      c0 = 0; c1 = 0; cp = 0; s0 = 0; s1 = 0; sp = 0;
    end else begin
      logic rise, fall, sfall;
      rise = c1 && !cp;
      fall = !c1 && cp;
      sfall = !s1 && sp;
      mViol = rise && (mPhase == 3);
      case (mPhase)
        0: if (rise) begin mPhase = 1; mCnt = CONV_CYCLES - 1; mWord = sampleIn; end
        1, 2: begin
          if (fall) begin mPhase = 3; mCnt = ACQ_CYCLES - 1; mIdx = DATA_W - 1; end
          else if (mPhase == 1) begin
            if (mCnt == 0) mPhase = 2; else mCnt--;
          end
        end
        default: begin
          if (sfall && !c1) mIdx--;
          if (rise) begin mPhase = 1; mCnt = CONV_CYCLES - 1; mWord = sampleIn; end
          else if (mPhase == 3) begin
            if (mCnt == 0) mPhase = 4; else mCnt--;
          end
        end
      endcase
      cp = c1; c1 = c0; c0 = convIn;
      sp = s1; s1 = s0; s0 = sckIn;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expEn, expSdo;
      string ptag, stag;
      expEn = (mPhase >= 3);
      expSdo = expEn && (mIdx >= 0) ? mWord[mIdx] : 1'b0;
      case (mPhase)
        0: ptag = "R8 phase";
        1: ptag = "R1 phase";
        2: ptag = "R2 phase";
        3: ptag = "R3 phase";
        default: ptag = "R6 phase";
      endcase
      if (!expEn) stag = "R9 sdoOut";
      else if (mIdx == DATA_W - 1) stag = "R3 sdoOut";
      else if (mIdx >= 0) stag = "R4 sdoOut";
      else stag = "R5 sdoOut";
      check(phase == 3'(mPhase), ptag, phase, mPhase);
      check(sdoEn == expEn, "R3 sdoEn", sdoEn, expEn);
      check(sdoOut == expSdo, stag, sdoOut, expSdo);
      check(acqViolation == mViol, "R7 acqViolation", acqViolation, mViol);
      if (acqViolation) violSeen++;
    end
  end

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseSck(input int n);
    for (int i = 0; i < n; i++) begin
      sckIn = 1'b1; waitClk(2);
      sckIn = 1'b0; waitClk(2);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    waitClk(3);
    check(phase == 3'd0, "R8 reset phase", phase, 0);
    check(!sdoEn && !sdoOut, "R8 reset sdo", {sdoEn, sdoOut}, 0);
    check(!acqViolation, "R8 reset flag", acqViolation, 0);
    rstN = 1'b1;
    waitClk(2);

    // A: long start pulse, sleep, full readout plus zero tail
    sampleIn = 12'hA5C; convIn = 1'b1; waitClk(20);
    check(phase == 3'd2, "R2 sleep reached", phase, 2);
    convIn = 1'b0; waitClk(10);
    check(phase == 3'd4, "R6 shifting reached", phase, 4);
    pulseSck(16);
    check(sdoEn && !sdoOut, "R5 zero tail", sdoOut, 0);

    // B: fall during converting, then early restart inside acquisition
    sampleIn = 12'h3C5; convIn = 1'b1; waitClk(4);
    convIn = 1'b0; waitClk(2);
    convIn = 1'b1; waitClk(20);
    convIn = 1'b0; waitClk(3);
    pulseSck(14);

    // C: single low bit, restart after acquisition (no flag)
    sampleIn = 12'h001; waitClk(4); convIn = 1'b1; waitClk(12);
    convIn = 1'b0; waitClk(3); pulseSck(3); waitClk(10);
    sampleIn = 12'h800; convIn = 1'b1; waitClk(15);
    convIn = 1'b0; waitClk(8);
    pulseSck(13);

    // D: all ones with clocks starting during acquisition
    sampleIn = 12'hFFF; convIn = 1'b1; waitClk(16);
    convIn = 1'b0; waitClk(1);
    pulseSck(17);
    waitClk(4);

    check(violSeen == 1, "R7 violation count", violSeen, 1);
    finishRun();
  end
endmodule